// File: doc/BRIEF.md
# Control Word Decoder with Serial Loader

This block sits behind an 8-bit byte link and turns every four bytes into a 32-bit control word. The bytes arrive as a valid/ready stream, most significant byte first. A word is acted on only when its fourth byte has been accepted. The top four bits of the word pick one of sixteen indices, and the low 28 bits are the payload. Indices 0 to 13 are storage: the payload is written into a bank of configuration registers, which drive the rest of the converter board. Three clock-source selects are decoded straight out of register 5.

The two highest indices are commands and are not stored. Index 0xF runs an upload. Registers 0 to 4 are shifted into the DAC, and register 5 is shifted into each of the two clock synthesizers in turn. Each device has its own active-low select. Index 0xE runs a readback. The block reads fifteen DAC registers in ascending order over the same serial bus. It then returns each result as a 32-bit word, split into four bytes on an outgoing valid/ready stream. While either command runs, `busy` is high and the incoming byte stream is stalled.

Top module: `cwd_top`

## Requirements
- R1: Bytes are packed most significant byte first. Nothing in the register bank changes until the fourth byte of a word has been accepted.
- R2: A word with index `w[31:28]` in 0..13 stores `w[27:0]` into register idx. The value appears on `cfg_regs[idx*28 +: 28]` within two cycles of the fourth byte.
- R3: Bit 23 of register 0 selects a bidirectional serial data pin and is always held at 0. It is cleared on store, so it is also 0 in the copy that is shifted out.
- R4: `clk_ext_adca`, `clk_ext_adcb` and `clk_ext_dac` equal register 5 bits 27, 26 and 25. A value of 1 means external and 0 means internal.
- R5: Index 0xF makes seven serial transfers in this order: registers 0..4 to the DAC (`spi_cs_n[0]`), then register 5 to synthesizer A (`spi_cs_n[1]`), then register 5 to synthesizer B (`spi_cs_n[2]`). Each transfer is 28 bits, MSB first. No more than one select is low at any time.
- R6: Index 0xE makes fifteen 16-bit DAC transfers for addresses 0..14 in ascending order. Each sends the command byte `{1, 000, addr[3:0]}` followed by eight zero bits. The data byte is taken from `spi_miso` on the last eight rising clock edges.
- R7: Each read result is returned as the word `{4'hE, addr[3:0], 16'h0000, data[7:0]}`, as four bytes MSB first on `tx_data`. That gives 60 bytes in total. While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value.
- R8: `busy` is high from the cycle after a command word is taken until its last transfer or byte is finished. `rx_ready` is low whenever `busy` is high, so the next word is not accepted until the command has finished.
- R9: After a synchronous reset, all registers are zero, all selects are high, `spi_sclk` is low, and `busy` and `tx_valid` are low.
- R10: The serial clock stays high for `CLK_DIV` system cycles on each bit and is low for the same length. `spi_mosi` changes only while the serial clock is low.
- R11: Command words (indices 0xE and 0xF) leave every stored register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Block accepts the byte this cycle |
| tx_data | output | 8 | Returned readback byte |
| tx_valid | output | 1 | Returned byte valid |
| tx_ready | input | 1 | Sink accepts the returned byte |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to devices |
| spi_miso | input | 1 | Serial data from the DAC |
| spi_cs_n | output | 3 | Active-low selects: DAC, synthesizer A, synthesizer B |
| busy | output | 1 | Upload or readback in progress |
| clk_ext_adca | output | 1 | ADC A clock source external |
| clk_ext_adcb | output | 1 | ADC B clock source external |
| clk_ext_dac | output | 1 | DAC clock source external |
| cfg_regs | output | 392 | Registers 0..13, 28 bits each, register 0 in the low bits |

## Verification
The hardest case to reach from the ports is a word that arrives while a command is still running. Its bytes must stay outside the block until the last select has risen. The bench triggers this by issuing an upload and then at once offering another storage word. It checks that all seven transfers were logged before that word's first byte was accepted. The readback path needs a serial device that answers with address-dependent data. A bench model of the DAC decodes the command byte and drives read data on falling serial clock edges. The return stream is throttled with a repeating ready pattern, so that bytes held under backpressure are exercised.

// File: rtl/cwd_pkg.sv
// Shared types and command codes for the control word decoder.
// Assumes a 4-bit register index in the top of every control word.
package cwd_pkg;

    // Sequencer states for the command engine
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_UP_GO,
        SQ_UP_WAIT,
        SQ_RB_GO,
        SQ_RB_WAIT,
        SQ_TX
    } seq_state_t;

    // Indices that start a command instead of being stored
    localparam logic [3:0] IDX_READBACK = 4'hE;
    localparam logic [3:0] IDX_UPLOAD   = 4'hF;

endpackage

// File: rtl/cwd_byte_asm.sv
// Packs incoming bytes, most significant first, into control words.
// Emits a one-cycle word strobe after the last byte. Stalls input while
// the command engine is busy and in the cycle of the strobe.
module cwd_byte_asm #(
    parameter int BYTE_W = 8,
    parameter int BYTES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BYTE_W-1:0]         in_data,
    input  logic                      in_valid,
    input  logic                      hold,
    output logic                      in_ready,
    output logic [BYTE_W*BYTES-1:0]   word,
    output logic                      word_valid
);

    localparam int WORD_W = BYTE_W * BYTES;
    localparam int ACC_W  = WORD_W - BYTE_W;
    localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1;

    logic [ACC_W-1:0] acc;
    logic [CNT_W-1:0] cnt;

    // Ready only when idle and not presenting a fresh word
    assign in_ready = !hold && !word_valid;

    // Shift accepted bytes in and fire the word strobe on the last one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            cnt        <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (in_valid && in_ready) begin
                if (cnt == CNT_W'(BYTES - 1)) begin
                    word       <= {acc, in_data};
                    word_valid <= 1'b1;
                    cnt        <= '0;
                end else begin
                    acc <= {acc[ACC_W-BYTE_W-1:0], in_data};
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R1: a word strobe always follows an accepted byte
    p_word_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(in_valid && in_ready));

endmodule

// File: rtl/cwd_regbank.sv
// Configuration register bank written by storage words.
// Indices at or above NUM_REGS are ignored. Register 0 keeps its serial
// direction bit cleared.
module cwd_regbank #(
    parameter int NUM_REGS = 14,
    parameter int PAY_W    = 28,
    parameter int IDX_W    = 4,
    parameter int DIR_BIT  = 23
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PAY_W-1:0]          wr_data,
    output logic [NUM_REGS*PAY_W-1:0] regs_o
);

    localparam logic [PAY_W-1:0] DIR_MASK = ~(PAY_W'(1) << DIR_BIT);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [PAY_W-1:0] r;
        if (g == 0) begin : g_masked
            // Register 0 store with direction bit forced low
            always_ff @(posedge clk) begin
                if (!rst_n)                                 r <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))      r <= wr_data & DIR_MASK;
            end
        end else begin : g_plain
            // Plain register store on index match
            always_ff @(posedge clk) begin
                if (!rst_n)                                 r <= '0;
                else if (wr_en && wr_idx == IDX_W'(g))      r <= wr_data;
            end
        end
        assign regs_o[g*PAY_W +: PAY_W] = r;
    end

    // R3: direction bit of register 0 never set
    p_dir_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        regs_o[DIR_BIT] == 1'b0);

    // R11: out-of-range (command) indices leave the bank untouched
    p_cmd_no_store_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs_o));

endmodule

// File: rtl/cwd_spi_engine.sv
// Single serial transfer engine. It shifts a left-aligned vector out MSB
// first on one chip select and samples miso on each rising serial clock.
// Clock halves last CLK_DIV system cycles. Assumes start only while idle.
module cwd_spi_engine #(
    parameter int NUM_DEV = 3,
    parameter int SR_W    = 32,
    parameter int RX_W    = 8,
    parameter int CLK_DIV = 3,
    parameter int DEV_W   = 2,
    parameter int LEN_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [DEV_W-1:0]   dev_sel,
    input  logic [SR_W-1:0]    tx_bits,
    input  logic [LEN_W-1:0]   nbits,
    input  logic               miso,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               sclk,
    output logic               mosi,
    output logic               done,
    output logic [RX_W-1:0]    rx_data
);

    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic             active;
    logic [DIV_W-1:0] div;
    logic [LEN_W-1:0] left;
    logic [SR_W-1:0]  sr;

    // Data line follows the shift register head while a transfer runs
    assign mosi = active & sr[SR_W-1];

    // Transfer sequencing: select, clock halves, shift, sample, release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            div     <= '0;
            left    <= '0;
            sr      <= '0;
            rx_data <= '0;
            done    <= 1'b0;
            cs_n    <= '1;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active <= 1'b1;
                    sr     <= tx_bits;
                    left   <= nbits;
                    div    <= '0;
                    sclk   <= 1'b0;
                    cs_n   <= ~(NUM_DEV'(1) << dev_sel);
                end
            end else if (div == DIV_W'(CLK_DIV - 1)) begin
                div <= '0;
                if (!sclk) begin
                    sclk    <= 1'b1;
                    rx_data <= {rx_data[RX_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    sr   <= sr << 1;
                    left <= left - 1'b1;
                    if (left == LEN_W'(1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        cs_n   <= '1;
                    end
                end
            end else begin
                div <= div + 1'b1;
            end
        end
    end

    // R5: at most one device selected
    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R10: data stable throughout the clock-high half
    p_mosi_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sclk && $past(sclk) |-> $stable(mosi));

    // R9: idle engine keeps selects high and the clock low
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (cs_n == '1 && !sclk));

    // R5: a new transfer is never started on top of a running one
    p_start_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !active);

endmodule

// File: rtl/cwd_sequencer.sv
// Command engine. An upload walks registers 0..DAC_REGS-1 to the DAC,
// then register DAC_REGS to each synthesizer. A readback walks RB_WORDS
// DAC addresses and streams every result out as four bytes.
// Assumes the serial engine is idle whenever a GO state is entered.
module cwd_sequencer
    import cwd_pkg::*;
#(
    parameter int BYTE_W   = 8,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = 4,
    parameter int PAY_W    = 28,
    parameter int DAC_REGS = 5,
    parameter int NUM_DEV  = 3,
    parameter int RB_WORDS = 15,
    parameter int DEV_W    = 2,
    parameter int LEN_W    = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_valid,
    input  logic [IDX_W-1:0]              cmd_idx,
    input  logic [(DAC_REGS+1)*PAY_W-1:0] regs,
    input  logic                          eng_done,
    input  logic [BYTE_W-1:0]             eng_rx,
    output logic                          eng_start,
    output logic [DEV_W-1:0]              eng_dev,
    output logic [WORD_W-1:0]             eng_bits,
    output logic [LEN_W-1:0]              eng_nbits,
    output logic [BYTE_W-1:0]             tx_data,
    output logic                          tx_valid,
    input  logic                          tx_ready,
    output logic                          busy
);

    localparam int UP_STEPS  = DAC_REGS + NUM_DEV - 1;
    localparam int MAX_STEPS = (UP_STEPS > RB_WORDS) ? UP_STEPS : RB_WORDS;
    localparam int STEP_W    = $clog2(MAX_STEPS);
    localparam int NBYTES    = WORD_W / BYTE_W;
    localparam int BSEL_W    = $clog2(NBYTES);
    localparam int PAD_W     = WORD_W - 2 * IDX_W - BYTE_W;

    seq_state_t          state;
    logic [STEP_W-1:0]   step;
    logic [BSEL_W-1:0]   bsel;
    logic [WORD_W-1:0]   rb_word;
    logic [STEP_W-1:0]   up_reg;
    logic [DEV_W-1:0]    up_dev;
    logic [PAY_W-1:0]    up_pay;
    logic [BYTE_W-1:0]   rd_cmd;

    // Pick register, device and transfer vector for the current step
    always_comb begin
        if (step < STEP_W'(DAC_REGS)) begin
            up_reg = step;
            up_dev = '0;
        end else begin
            up_reg = STEP_W'(DAC_REGS);
            up_dev = DEV_W'(step - STEP_W'(DAC_REGS)) + DEV_W'(1);
        end
        up_pay    = regs[up_reg*PAY_W +: PAY_W];
        rd_cmd    = {1'b1, (BYTE_W-1)'(step)};
        eng_start = (state == SQ_UP_GO) || (state == SQ_RB_GO);
        if (state == SQ_RB_GO) begin
            eng_dev   = '0;
            eng_bits  = {rd_cmd, {(WORD_W-BYTE_W){1'b0}}};
            eng_nbits = LEN_W'(2 * BYTE_W);
        end else begin
            eng_dev   = up_dev;
            eng_bits  = {up_pay, {(WORD_W-PAY_W){1'b0}}};
            eng_nbits = LEN_W'(PAY_W);
        end
    end

    // Return stream and busy flag come straight from the state
    assign tx_valid = (state == SQ_TX);
    assign tx_data  = rb_word[WORD_W-1 - bsel*BYTE_W -: BYTE_W];
    assign busy     = (state != SQ_IDLE);

    // Command state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SQ_IDLE;
            step    <= '0;
            bsel    <= '0;
            rb_word <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (cmd_valid && cmd_idx == IDX_UPLOAD) begin
                        step  <= '0;
                        state <= SQ_UP_GO;
                    end else if (cmd_valid && cmd_idx == IDX_READBACK) begin
                        step  <= '0;
                        state <= SQ_RB_GO;
                    end
                end
                SQ_UP_GO: state <= SQ_UP_WAIT;
                SQ_UP_WAIT: begin
                    if (eng_done) begin
                        if (step == STEP_W'(UP_STEPS - 1)) begin
                            state <= SQ_IDLE;
                        end else begin
                            step  <= step + 1'b1;
                            state <= SQ_UP_GO;
                        end
                    end
                end
                SQ_RB_GO: state <= SQ_RB_WAIT;
                SQ_RB_WAIT: begin
                    if (eng_done) begin
                        rb_word <= {IDX_READBACK, IDX_W'(step), {PAD_W{1'b0}}, eng_rx};
                        bsel    <= '0;
                        state   <= SQ_TX;
                    end
                end
                SQ_TX: begin
                    if (tx_ready) begin
                        if (bsel == BSEL_W'(NBYTES - 1)) begin
                            if (step == STEP_W'(RB_WORDS - 1)) begin
                                state <= SQ_IDLE;
                            end else begin
                                step  <= step + 1'b1;
                                state <= SQ_RB_GO;
                            end
                        end else begin
                            bsel <= bsel + 1'b1;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R7: a stalled byte is held unchanged
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    // R8: no return traffic outside a command
    p_tx_only_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> busy);

endmodule

// File: rtl/cwd_top.sv
// Control word decoder with serial loader: byte packer, register bank,
// command sequencer and serial engine. Assumes a free-running clock and
// a synchronous active-low reset.
module cwd_top #(
    parameter int BYTE_W   = 8,
    parameter int BYTES    = 4,
    parameter int IDX_W    = 4,
    parameter int NUM_REGS = 14,
    parameter int DAC_REGS = 5,
    parameter int NUM_DEV  = 3,
    parameter int RB_WORDS = 15,
    parameter int DIR_BIT  = 23,
    parameter int CKSEL_HI = 27,
    parameter int CLK_DIV  = 3
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic [BYTE_W-1:0]                             rx_data,
    input  logic                                          rx_valid,
    output logic                                          rx_ready,
    output logic [BYTE_W-1:0]                             tx_data,
    output logic                                          tx_valid,
    input  logic                                          tx_ready,
    output logic                                          spi_sclk,
    output logic                                          spi_mosi,
    input  logic                                          spi_miso,
    output logic [NUM_DEV-1:0]                            spi_cs_n,
    output logic                                          busy,
    output logic                                          clk_ext_adca,
    output logic                                          clk_ext_adcb,
    output logic                                          clk_ext_dac,
    output logic [NUM_REGS*(BYTE_W*BYTES-IDX_W)-1:0]      cfg_regs
);

    localparam int WORD_W = BYTE_W * BYTES;
    localparam int PAY_W  = WORD_W - IDX_W;
    localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int LEN_W  = $clog2(WORD_W + 1);

    logic [WORD_W-1:0] word;
    logic              word_valid;
    logic              eng_start;
    logic [DEV_W-1:0]  eng_dev;
    logic [WORD_W-1:0] eng_bits;
    logic [LEN_W-1:0]  eng_nbits;
    logic              eng_done;
    logic [BYTE_W-1:0] eng_rx;
    logic [PAY_W-1:0]  ck_reg;

    cwd_byte_asm #(.BYTE_W(BYTE_W), .BYTES(BYTES)) u_asm (
        .clk(clk), .rst_n(rst_n), .in_data(rx_data), .in_valid(rx_valid),
        .hold(busy), .in_ready(rx_ready), .word(word), .word_valid(word_valid)
    );

    cwd_regbank #(.NUM_REGS(NUM_REGS), .PAY_W(PAY_W), .IDX_W(IDX_W),
                  .DIR_BIT(DIR_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(word_valid),
        .wr_idx(word[WORD_W-1 -: IDX_W]), .wr_data(word[PAY_W-1:0]),
        .regs_o(cfg_regs)
    );

    cwd_sequencer #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .IDX_W(IDX_W),
                    .PAY_W(PAY_W), .DAC_REGS(DAC_REGS), .NUM_DEV(NUM_DEV),
                    .RB_WORDS(RB_WORDS), .DEV_W(DEV_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(word_valid),
        .cmd_idx(word[WORD_W-1 -: IDX_W]),
        .regs(cfg_regs[(DAC_REGS+1)*PAY_W-1:0]),
        .eng_done(eng_done), .eng_rx(eng_rx), .eng_start(eng_start),
        .eng_dev(eng_dev), .eng_bits(eng_bits), .eng_nbits(eng_nbits),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .busy(busy)
    );

    cwd_spi_engine #(.NUM_DEV(NUM_DEV), .SR_W(WORD_W), .RX_W(BYTE_W),
                     .CLK_DIV(CLK_DIV), .DEV_W(DEV_W), .LEN_W(LEN_W)) u_spi (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .dev_sel(eng_dev),
        .tx_bits(eng_bits), .nbits(eng_nbits), .miso(spi_miso),
        .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
        .done(eng_done), .rx_data(eng_rx)
    );

    // Clock-source selects decoded from the clock management register
    assign ck_reg       = cfg_regs[DAC_REGS*PAY_W +: PAY_W];
    assign clk_ext_adca = ck_reg[CKSEL_HI];
    assign clk_ext_adcb = ck_reg[CKSEL_HI-1];
    assign clk_ext_dac  = ck_reg[CKSEL_HI-2];

    // R8: input stalled for the whole command
    p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rx_ready);

    // R5: selects only move while a command runs
    p_cs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n == '1));

endmodule

// File: tb/test_cwd_top.sv
`timescale 1ns/1ps
module test_cwd_top;

    localparam int CLK_DIV = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   rx_data = '0;
    logic         rx_valid = 1'b0;
    logic         rx_ready;
    logic [7:0]   tx_data;
    logic         tx_valid;
    logic         tx_ready = 1'b0;
    logic         spi_sclk, spi_mosi;
    logic         spi_miso = 1'b0;
    logic [2:0]   spi_cs_n;
    logic         busy, clk_ext_adca, clk_ext_adcb, clk_ext_dac;
    logic [391:0] cfg_regs;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cwd_top #(.CLK_DIV(CLK_DIV)) i_cwd_top (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .busy(busy),
        .clk_ext_adca(clk_ext_adca), .clk_ext_adcb(clk_ext_adcb),
        .clk_ext_dac(clk_ext_dac), .cfg_regs(cfg_regs)
    );

    // Stimulus table: {control word, expected stored payload}
    localparam logic [59:0] VEC [8] = '{
        {32'h0ABCDEF1, 28'hA3CDEF1},
        {32'h12345678, 28'h2345678},
        {32'h2FEDCBA9, 28'hFEDCBA9},
        {32'h30000001, 28'h0000001},
        {32'h48000000, 28'h8000000},
        {32'h5A000055, 28'hA000055},
        {32'h71234567, 28'h1234567},
        {32'hD0F0F0F0, 28'h0F0F0F0}
    };

    logic [27:0] mdl [14];

    // Serial endpoint models: capture per select, DAC answers reads
    logic [31:0] cap = '0;
    int          bits = 0;
    logic [3:0]  rd_addr = '0;
    bit          log_en = 0;
    int          log_n = 0;
    int          log_dev [32];
    logic [31:0] log_word [32];
    int          log_len [32];

    function automatic logic [7:0] rb_val(input logic [3:0] a);
        return 8'(a * 37 + 27);
    endfunction

    task automatic log_xfer(input int d);
        if (log_en && log_n < 32) begin
            log_dev[log_n]  = d;
            log_word[log_n] = cap;
            log_len[log_n]  = bits;
            log_n++;
        end
    endtask

    always @(negedge spi_cs_n[0] or negedge spi_cs_n[1] or negedge spi_cs_n[2]) begin
        cap  = '0;
        bits = 0;
    end
    always @(posedge spi_sclk) begin
        if (spi_cs_n != 3'b111) begin
            cap = {cap[30:0], spi_mosi};
            bits++;
            if (bits == 8) rd_addr = cap[3:0];
        end
    end
    always @(negedge spi_sclk) begin
        if (!spi_cs_n[0] && bits >= 8 && bits < 16) spi_miso = rb_val(rd_addr)[15-bits];
    end
    always @(posedge spi_cs_n[0]) log_xfer(0);
    always @(posedge spi_cs_n[1]) log_xfer(1);
    always @(posedge spi_cs_n[2]) log_xfer(2);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] d);
        @(negedge clk);
        rx_data  = d;
        rx_valid = 1'b1;
        while (!rx_ready) @(negedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int b = 0; b < 4; b++) send_byte(w[31-8*b -: 8]);
    endtask

    task automatic wait_idle();
        int lim = 0;
        while (busy && lim < 50000) begin
            @(negedge clk);
            lim++;
        end
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < 14; i++)
            check(req, $sformatf("reg%0d", i), 64'(cfg_regs[i*28 +: 28]), 64'(mdl[i]));
    endtask

    initial begin
        for (int i = 0; i < 14; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        log_en = 1;

        // R9: reset state
        check("R9", "cs_n", 64'(spi_cs_n), 64'h7);
        check("R9", "sclk", 64'(spi_sclk), 64'h0);
        check("R9", "busy", 64'(busy), 64'h0);
        check("R9", "tx_valid", 64'(tx_valid), 64'h0);
        check("R9", "rx_ready", 64'(rx_ready), 64'h1);
        check_bank("R9");

        // R2 (R3 on entry 0): table of storage words
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = int'(VEC[i][59:56]);
            send_word(VEC[i][59:28]);
            repeat (2) @(negedge clk);
            mdl[idx] = VEC[i][27:0];
            check(i == 0 ? "R3" : "R2", $sformatf("store idx %0d", idx),
                  64'(cfg_regs[idx*28 +: 28]), 64'(VEC[i][27:0]));
        end

        // R4: clock-source selects from register 5
        check("R4", "clk sel A/B/DAC", 64'({clk_ext_adca, clk_ext_adcb, clk_ext_dac}), 64'b101);
        send_word(32'h54000003);
        repeat (2) @(negedge clk);
        mdl[5] = 28'h4000003;
        check("R4", "clk sel after rewrite", 64'({clk_ext_adca, clk_ext_adcb, clk_ext_dac}), 64'b010);

        // R1: partial word has no effect, then MSB-first assembly
        send_byte(8'h61);
        send_byte(8'h23);
        send_byte(8'h45);
        repeat (4) @(negedge clk);
        check("R1", "reg6 before 4th byte", 64'(cfg_regs[6*28 +: 28]), 64'(mdl[6]));
        send_byte(8'h67);
        repeat (2) @(negedge clk);
        mdl[6] = 28'h1234567;
        check("R1", "reg6 after 4th byte", 64'(cfg_regs[6*28 +: 28]), 64'h1234567);

        // R5/R8/R10: upload command
        log_n = 0;
        send_word(32'hF0000000);
        begin
            int lim = 0;
            int hi = 0;
            while (!spi_sclk && lim < 1000) begin
                @(negedge clk);
                lim++;
            end
            while (spi_sclk && hi < 1000) begin
                @(negedge clk);
                hi++;
            end
            check("R10", "sclk high cycles", 64'(hi), 64'(CLK_DIV));
        end
        check("R8", "busy during upload", 64'(busy), 64'h1);
        check("R8", "rx_ready during upload", 64'(rx_ready), 64'h0);
        send_word(32'h6ABCDEF0);
        check("R8", "transfers done before next word taken", 64'(log_n), 64'd7);
        repeat (2) @(negedge clk);
        mdl[6] = 28'hABCDEF0;
        for (int k = 0; k < 7; k++) begin
            int ed;
            logic [27:0] ep;
            ed = (k < 5) ? 0 : k - 4;
            ep = (k < 5) ? mdl[k] : mdl[5];
            check("R5", $sformatf("xfer %0d device", k), 64'(log_dev[k]), 64'(ed));
            check("R5", $sformatf("xfer %0d length", k), 64'(log_len[k]), 64'd28);
            check("R5", $sformatf("xfer %0d data", k), 64'(log_word[k][27:0]), 64'(ep));
        end
        check("R3", "uploaded reg0 bit23", 64'(log_word[0][23]), 64'h0);
        check_bank("R11");

        // R6/R7: readback with a throttled return stream
        log_n = 0;
        send_word(32'hE0000000);
        begin
            logic [7:0] rbytes [60];
            int   got = 0;
            int   cyc = 0;
            int   stab_err = 0;
            bit   prev_stall = 0;
            logic [7:0] prev_data = '0;
            while (got < 60 && cyc < 40000) begin
                @(negedge clk);
                cyc++;
                if (prev_stall && tx_data !== prev_data) stab_err++;
                tx_ready = (cyc % 3) != 0;
                if (tx_valid && tx_ready) begin
                    rbytes[got] = tx_data;
                    got++;
                end
                prev_stall = tx_valid && !tx_ready;
                prev_data  = tx_data;
            end
            @(negedge clk);
            tx_ready = 1'b0;
            check("R7", "byte count", 64'(got), 64'd60);
            check("R7", "stalled byte held", 64'(stab_err), 64'd0);
            for (int k = 0; k < 15; k++) begin
                check("R7", $sformatf("word %0d", k),
                      64'({rbytes[4*k], rbytes[4*k+1], rbytes[4*k+2], rbytes[4*k+3]}),
                      64'({4'hE, 4'(k), 16'h0000, rb_val(4'(k))}));
            end
        end
        wait_idle();
        check("R6", "read transfer count", 64'(log_n), 64'd15);
        for (int k = 0; k < 15; k++) begin
            check("R6", $sformatf("read %0d frame", k),
                  64'({log_dev[k], log_len[k], log_word[k][15:0]}),
                  64'({32'd0, 32'd16, 1'b1, 3'b000, 4'(k), 8'h00}));
        end
        check("R8", "idle after readback", 64'({busy, rx_ready}), 64'b01);
        check_bank("R11");

        // R9: reset in mid-life clears the bank
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 14; i++) mdl[i] = '0;
        check_bank("R9");
        check("R9", "clk selects", 64'({clk_ext_adca, clk_ext_adcb, clk_ext_dac}), 64'b000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual running expected done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule